// File: doc/BRIEF.md
# IrDA Frame Byte Stuffer

This block turns a stream of raw frame payload bytes into a framed byte stream for an infrared link. The first payload byte of a frame is marked with a start marker and the last with an end marker. The block puts the flag characters of the selected link mode around the frame. It replaces every payload byte that is reserved in that mode with a two-byte escape: a common prefix `0x7D` followed by the original byte XOR `0x20`. Three modes exist: slow (SIR), medium (MIR) and fast (FIR). Fast mode also sends a configurable number of pre-synchronisation characters before the start flag.

Both sides are valid/ready byte streams. In the payload phase a non-reserved byte passes straight through in the cycle it arrives, with no extra register. The mode input is captured when a new frame is seen. It stays fixed until the end flag of that frame has been accepted downstream. The stuffer sits between a frame source (which already holds address, control, information and check fields) and the serial modulator.

Top module: `irda_frame_stuffer`

## Requirements
- R1: With mode code 0 (SIR), and also with code 3, which behaves as SIR, a frame is sent as start flag `0xC0`, the stuffed payload, then end flag `0xC1`.
- R2: With mode code 1 (MIR), a frame is sent as `0x7E`, the stuffed payload, then `0x7E`.
- R3: With mode code 2 (FIR), a frame is sent as PRESYNC_N copies of `0x7F` (default 1), then `0x7E`, the stuffed payload, then `0x7E`.
- R4: A payload byte reserved in the frame's mode is sent as `0x7D` followed by the byte XOR `0x20`. The reserved sets are {`0xC0`, `0xC1`, `0x7D`} for SIR, {`0x7E`, `0x7D`} for MIR and {`0x7F`, `0x7E`, `0x7D`} for FIR.
- R5: A payload byte not reserved in the frame's mode is sent unchanged as one byte (for example `0xC0` in MIR, or `0x7E` and `0x7F` in SIR).
- R6: The mode is taken when the start-marked byte is first seen in the idle state. A change of the mode input later in the frame has no effect on that frame.
- R7: While the second byte of an escape is offered, in_ready is low, so one input byte never gives more than two output bytes.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R9: In the idle state, a valid byte without the start marker is accepted and dropped, and it produces no output.
- R10: After reset the block is idle: out_valid is low, and in_ready is high while in_sof is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Link mode: 0 SIR, 1 MIR, 2 FIR, 3 SIR |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Payload byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Framed, stuffed byte |

## Verification
Payloads are run in every mode. They mix three kinds of byte: bytes reserved in the current mode, bytes reserved only in some other mode, and ordinary bytes. This shows the per-mode reserved sets are kept apart rather than merged. Single-byte frames separate the start-and-end handling from the body path. Frames that end on an escaped byte check that the end flag comes after the second escape byte. The same table is run again under periodic downstream stalls, which checks stall stability and escape blocking against back-pressure. Directed cases cover dropping bytes that arrive outside a frame, and a mode switch in the middle of a frame.

// File: rtl/irda_stuff_pkg.sv
package irda_stuff_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] ESC_PREFIX = 8'h7D;
  localparam logic [BYTE_W-1:0] ESC_XOR    = 8'h20;
  localparam logic [BYTE_W-1:0] PRESYNC_CH = 8'h7F;
  localparam logic [BYTE_W-1:0] HS_FLAG    = 8'h7E;
  localparam logic [BYTE_W-1:0] LS_START   = 8'hC0;
  localparam logic [BYTE_W-1:0] LS_END     = 8'hC1;

  typedef enum logic [1:0] {
    LINK_SLOW  = 2'd0,
    LINK_MED   = 2'd1,
    LINK_FAST  = 2'd2,
    LINK_SLOW2 = 2'd3
  } link_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_OPEN,
    ST_BODY,
    ST_ESC,
    ST_CLOSE
  } stuff_state_e;

  function automatic logic is_slow(input link_mode_e m);
    return (m == LINK_SLOW) || (m == LINK_SLOW2);
  endfunction

  function automatic logic [BYTE_W-1:0] open_flag(input link_mode_e m);
    return is_slow(m) ? LS_START : HS_FLAG;
  endfunction

  function automatic logic [BYTE_W-1:0] close_flag(input link_mode_e m);
    return is_slow(m) ? LS_END : HS_FLAG;
  endfunction

  function automatic logic needs_escape(input link_mode_e m, input logic [BYTE_W-1:0] b);
    logic hit;
    hit = (b == ESC_PREFIX);
    case (m)
      LINK_MED:  hit = hit || (b == HS_FLAG);
      LINK_FAST: hit = hit || (b == HS_FLAG) || (b == PRESYNC_CH);
      default:   hit = hit || (b == LS_START) || (b == LS_END);
    endcase
    return hit;
  endfunction

  function automatic logic [BYTE_W-1:0] escaped_byte(input logic [BYTE_W-1:0] b);
    return b ^ ESC_XOR;
  endfunction

endpackage

// File: rtl/irda_esc_classify.sv
module irda_esc_classify
  import irda_stuff_pkg::*;
(
  input  link_mode_e        mode_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              reserved_o,
  output logic [BYTE_W-1:0] second_o
);

  always_comb begin
    reserved_o = needs_escape(mode_i, byte_i);
    second_o   = escaped_byte(byte_i);
  end

  // R4: the second escape byte always differs from the prefix
  always_comb begin
    if (reserved_o) begin
      a_r4_second_not_prefix: assert (second_o != ESC_PREFIX);
    end
  end

endmodule

// File: rtl/irda_presync_count.sv
module irda_presync_count #(
  parameter int unsigned COUNT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic last_o
);

  localparam int unsigned CW   = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam int unsigned LAST = (COUNT > 0) ? COUNT - 1 : 0;

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R3: the counter never runs past the last pre-sync slot
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LAST));

endmodule

// File: rtl/irda_stuff_seq.sv
module irda_stuff_seq
  import irda_stuff_pkg::*;
#(
  parameter int unsigned PRESYNC_N = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  link_mode_e        mode_in,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output link_mode_e        mode_q,
  input  logic              cls_reserved,
  input  logic [BYTE_W-1:0] cls_second,
  output logic              pre_step,
  input  logic              pre_last
);

  stuff_state_e      state_q, state_d;
  logic [BYTE_W-1:0] esc_q;
  logic              last_q;

  // named events for the assertions
  logic out_fire;
  logic frame_start;
  logic esc_begin;
  logic idle_drop;
  logic in_frame;

  assign out_fire    = out_valid && out_ready;
  assign frame_start = (state_q == ST_IDLE) && in_valid && in_sof;
  assign idle_drop   = (state_q == ST_IDLE) && in_valid && !in_sof;
  assign esc_begin   = (state_q == ST_BODY) && out_fire && cls_reserved;
  assign pre_step    = (state_q == ST_PRE) && out_fire;
  assign in_frame    = (state_q != ST_IDLE);

  // output and input handshake per state
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    unique case (state_q)
      ST_IDLE: begin
        in_ready = !in_sof;
      end
      ST_PRE: begin
        out_valid = 1'b1;
        out_data  = PRESYNC_CH;
      end
      ST_OPEN: begin
        out_valid = 1'b1;
        out_data  = open_flag(mode_q);
      end
      ST_BODY: begin
        out_valid = in_valid;
        out_data  = cls_reserved ? ESC_PREFIX : in_data;
        in_ready  = out_ready;
      end
      ST_ESC: begin
        out_valid = 1'b1;
        out_data  = esc_q;
      end
      ST_CLOSE: begin
        out_valid = 1'b1;
        out_data  = close_flag(mode_q);
      end
      default: begin
        out_valid = 1'b0;
      end
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_start) begin
          state_d = ((mode_in == LINK_FAST) && (PRESYNC_N > 0)) ? ST_PRE : ST_OPEN;
        end
      end
      ST_PRE: begin
        if (pre_step && pre_last) state_d = ST_OPEN;
      end
      ST_OPEN: begin
        if (out_fire) state_d = ST_BODY;
      end
      ST_BODY: begin
        if (out_fire) begin
          if (cls_reserved)  state_d = ST_ESC;
          else if (in_eof)   state_d = ST_CLOSE;
        end
      end
      ST_ESC: begin
        if (out_fire) state_d = last_q ? ST_CLOSE : ST_BODY;
      end
      ST_CLOSE: begin
        if (out_fire) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= LINK_SLOW;
      esc_q   <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (frame_start) begin
        mode_q <= mode_in;
      end
      if (esc_begin) begin
        esc_q  <= cls_second;
        last_q <= in_eof;
      end
    end
  end

  // R8: an offered byte stays put until taken
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: taking an escape prefix blocks the input for the next cycle
  a_r7_esc_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    esc_begin |=> !in_ready);

  // R4: the byte after an accepted prefix is the taken byte XOR 0x20
  a_r4_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
    esc_begin |=> (out_valid && (out_data == ($past(in_data) ^ ESC_XOR))));

  // R6: the frame mode does not move while a frame is open
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && $past(in_frame)) |-> $stable(mode_q));

  // R9: a stray byte in idle does not open a frame
  a_r9_drop_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle_drop |=> !in_frame);

  // R3: the last pre-sync byte is followed by the high-speed flag
  a_r3_flag_after_presync: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_step && pre_last) |=> (out_valid && (out_data == HS_FLAG)));

endmodule

// File: rtl/irda_frame_stuffer.sv
module irda_frame_stuffer
  import irda_stuff_pkg::*;
#(
  parameter int unsigned PRESYNC_N = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);

  link_mode_e        mode_sel;
  link_mode_e        mode_held;
  logic              cls_reserved;
  logic [BYTE_W-1:0] cls_second;
  logic              pre_step;
  logic              pre_last;

  assign mode_sel = link_mode_e'(mode);

  irda_esc_classify u_classify (
    .mode_i     (mode_held),
    .byte_i     (in_data),
    .reserved_o (cls_reserved),
    .second_o   (cls_second)
  );

  irda_presync_count #(
    .COUNT (PRESYNC_N)
  ) u_presync (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (pre_step),
    .last_o (pre_last)
  );

  irda_stuff_seq #(
    .PRESYNC_N (PRESYNC_N)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_in      (mode_sel),
    .in_valid     (in_valid),
    .in_sof       (in_sof),
    .in_eof       (in_eof),
    .in_data      (in_data),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_ready    (out_ready),
    .mode_q       (mode_held),
    .cls_reserved (cls_reserved),
    .cls_second   (cls_second),
    .pre_step     (pre_step),
    .pre_last     (pre_last)
  );

endmodule

// File: tb/irda_frame_stuffer_tb.sv
module irda_frame_stuffer_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       in_valid, in_ready, in_sof, in_eof;
  logic [7:0] in_data;
  logic       out_valid, out_ready;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  irda_frame_stuffer u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int total = 0;
  int bad   = 0;

  // vector: {mode, payload length, payload (byte 0 lowest), expected output length}
  localparam logic [42:0] VECS [0:7] = '{
    {2'd0, 3'd3, 32'h0022C011, 6'd6},
    {2'd0, 3'd4, 32'h7F7E7DC1, 6'd8},
    {2'd1, 3'd4, 32'h7FC07D7E, 6'd8},
    {2'd2, 3'd4, 32'h557D7E7F, 6'd10},
    {2'd2, 3'd1, 32'h000000C0, 6'd4},
    {2'd3, 3'd2, 32'h000000C0, 6'd5},
    {2'd1, 3'd1, 32'h0000005A, 6'd3},
    {2'd2, 3'd2, 32'h00007F20, 6'd6}
  };

  logic [7:0] exp_b [0:63];
  logic       exp_sec [0:63];
  string      exp_tag [0:63];
  int         exp_n;
  logic [7:0] cap_b [0:63];
  int         cap_n;
  logic       cap_en = 1'b0;
  logic       bp_en  = 1'b0;
  int         bp_cnt = 0;
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data  = 8'h00;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_res(input logic [1:0] m, input logic [7:0] b);
    case (m)
      2'd1:    return (b == 8'h7E) || (b == 8'h7D);
      2'd2:    return (b == 8'h7F) || (b == 8'h7E) || (b == 8'h7D);
      default: return (b == 8'hC0) || (b == 8'hC1) || (b == 8'h7D);
    endcase
  endfunction

  function automatic string flag_req(input logic [1:0] m);
    case (m)
      2'd1:    return "R2";
      2'd2:    return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic push(input logic [7:0] b, input bit sec, input string tag);
    exp_b[exp_n]   = b;
    exp_sec[exp_n] = sec;
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  task automatic build(input logic [1:0] m, input int len, input logic [31:0] pl,
                       input string over);
    string ft;
    ft = (over != "") ? over : flag_req(m);
    exp_n = 0;
    if (m == 2'd2) begin
      push(8'h7F, 1'b0, ft);
      push(8'h7E, 1'b0, ft);
    end else if (m == 2'd1) begin
      push(8'h7E, 1'b0, ft);
    end else begin
      push(8'hC0, 1'b0, ft);
    end
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = pl[8*i +: 8];
      if (is_res(m, b)) begin
        push(8'h7D, 1'b0, (over != "") ? over : "R4");
        push({b[7:6], ~b[5], b[4:0]}, 1'b1, (over != "") ? over : "R4");
      end else begin
        push(b, 1'b0, (over != "") ? over : "R5");
      end
    end
    push((m == 2'd0 || m == 2'd3) ? 8'hC1 : 8'h7E, 1'b0, ft);
  endtask

  // downstream ready pattern
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      out_ready = bp_en ? ((bp_cnt % 3) != 1) : 1'b1;
      bp_cnt++;
    end
  end

  // output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (cap_en) begin
      if (prev_stall) begin
        check(out_valid && (out_data == prev_data), "R8", "held byte",
              {23'd0, out_valid, out_data}, {24'd1, prev_data});
      end
      if (out_valid && cap_n < exp_n && exp_sec[cap_n]) begin
        check(!in_ready, "R7", "in_ready during escape second byte",
              int'(in_ready), 0);
      end
      if (out_valid && out_ready) begin
        if (cap_n < 64) cap_b[cap_n] = out_data;
        cap_n++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic send(input logic [7:0] b, input bit sof, input bit eof);
    in_data  = b;
    in_sof   = sof;
    in_eof   = eof;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
  endtask

  task automatic run_frame(input logic [1:0] m, input int len, input logic [31:0] pl,
                           input logic [1:0] m_after, input string over);
    build(m, len, pl, over);
    cap_n      = 0;
    prev_stall = 1'b0;
    cap_en     = 1'b1;
    mode       = m;
    for (int i = 0; i < len; i++) begin
      send(pl[8*i +: 8], i == 0, i == len - 1);
      if (i == 0) mode = m_after;
    end
    for (int k = 0; k < 60 && cap_n < exp_n; k++) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
    check(cap_n == exp_n, (over != "") ? over : flag_req(m), "output length", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      check(cap_b[i] == exp_b[i], exp_tag[i], $sformatf("byte %0d", i),
            cap_b[i], exp_b[i]);
    end
    cap_en = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R7 watchdog: actual=stalled expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    mode     = 2'd0;
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
    in_data  = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R10: idle after reset
    check(!out_valid, "R10", "out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R10", "in_ready after reset", int'(in_ready), 1);

    // table walk, free-flowing then with stalls
    for (int pass = 0; pass < 2; pass++) begin
      bp_en = (pass == 1);
      for (int v = 0; v < 8; v++) begin
        logic [42:0] e;
        e = VECS[v];
        run_frame(e[42:41], int'(e[40:38]), e[37:6], e[42:41], "");
        check(exp_n == int'(e[5:0]), "R4", $sformatf("vector %0d stuffed length", v),
              exp_n, int'(e[5:0]));
      end
    end
    bp_en = 1'b0;

    // R9: stray byte while idle is dropped
    cap_n      = 0;
    exp_n      = 0;
    prev_stall = 1'b0;
    cap_en     = 1'b1;
    send(8'hC0, 1'b0, 1'b0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(cap_n == 0, "R9", "outputs after stray byte", cap_n, 0);
    check(!out_valid, "R9", "out_valid after stray byte", int'(out_valid), 0);
    cap_en = 1'b0;

    // R6: mode input switched to SIR after the first byte of a FIR frame
    run_frame(2'd2, 3, 32'h00C1C07F, 2'd0, "R6");

    // R6: MIR frame, input switched to FIR mid-frame: 0x7F must pass plain
    run_frame(2'd1, 2, 32'h00007F7E, 2'd2, "R6");

    // frame right after a frame with the mode changed back in idle
    run_frame(2'd0, 1, 32'h0000007D, 2'd0, "");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule